// File: doc/BRIEF.md
# Clocked Synchronous Serial Shifter

This block moves bytes over a two-wire synchronous link made of a clock line and a data line. Each byte takes exactly eight clock pulses. Outgoing bits change only while the clock is low. Incoming bits are captured on the rising clock edge. A runtime mode input decides the clock source. As master, the block divides the system clock to make the line clock. As slave, it follows a clock from outside, which it passes through a two-flop synchronizer before it looks for edges.

The host side is a simple register-style port. Writing `tx_data` with `tx_wr` fills a transmit holding register and clears `tx_empty`. When the shifter takes the byte, `tx_empty` is set again. A finished incoming byte lands in a receive holding register and sets `rx_full`. Pulsing `rx_rd` consumes the byte. If a byte finishes while the previous one is still unread, `overrun` is raised and the unread byte is kept.

Two further inputs set the line format: `lsb_first` chooses the bit order, and `idle_level` sets what the data line drives whenever no byte is in flight.

Top module: `sync_serial_shifter`

## Requirements
- R1: After reset, `tx_empty`=1, `rx_full`=0, `overrun`=0, `busy`=0, `sclk_out`=1 and `sdata_out` equals `idle_level`.
- R2: In master mode (`master`=1, `sclk_oe`=1), each byte puts exactly 8 pulses on `sclk_out`. Each low phase lasts HALF_PERIOD system clocks. The clock is high whenever `busy`=0.
- R3: In master mode, a transfer begins only when `tx_empty`=0. With no byte waiting, `sclk_out` stays high and `busy` stays 0.
- R4: `sdata_out` changes only after a falling line-clock edge and holds its value for the whole high phase. `sdata_in` is sampled on the rising line-clock edge.
- R5: With `lsb_first`=1, bit 0 of a byte goes first on the line and is the first bit received. With `lsb_first`=0, bit 7 goes first. Both directions follow this rule.
- R6: While `busy`=0, `sdata_out` equals `idle_level`.
- R7: `tx_wr` clears `tx_empty` at the next clock edge. `tx_empty` returns to 1 when the shifter loads the byte.
- R8: After the 8th rising edge, the assembled byte appears on `rx_data` with `rx_full`=1. A one-cycle `rx_rd` clears `rx_full`.
- R9: If a byte completes while `rx_full`=1 and `rx_rd`=0, then `overrun` becomes 1 and `rx_data` keeps the earlier byte. `rx_rd` clears both `rx_full` and `overrun`.
- R10: In slave mode (`master`=0), `sclk_oe`=0 and `sclk_out`=1. The shifter follows `sclk_in` edges after a two-flop synchronizer.
- R11: In slave mode, the transmit register is loaded on the first falling edge of `sclk_in` seen while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master | input | 1 | 1: generate line clock, 0: follow `sclk_in` |
| lsb_first | input | 1 | Bit order select |
| idle_level | input | 1 | Data line level between bytes |
| tx_wr | input | 1 | Write strobe for `tx_data` |
| tx_data | input | W | Byte to send |
| tx_empty | output | 1 | Transmit register free |
| rx_rd | input | 1 | Consume received byte |
| rx_data | output | W | Last received byte |
| rx_full | output | 1 | Received byte waiting |
| overrun | output | 1 | A byte was lost to an unread one |
| busy | output | 1 | Byte in flight |
| sclk_in | input | 1 | External line clock (slave) |
| sclk_out | output | 1 | Generated line clock (master) |
| sclk_oe | output | 1 | Drive enable for `sclk_out` |
| sdata_in | input | 1 | Incoming serial data |
| sdata_out | output | 1 | Outgoing serial data |

## Verification
Random byte pairs are exchanged in both clock modes, with bit order and idle level drawn at random per byte. Any bit reversal, off-by-one shift or missed pulse shows up as a mismatch in the reassembled byte in one direction or the other. Directed cases cover three situations: a master that has nothing to send and must keep the clock quiet, two bytes received back to back without a read (which separates overrun from silent overwrite), and an idle data line checked against both idle levels. While the line clock is high, the bench compares the data line with the bit it latched at the rising edge. This catches data that changes in the wrong phase.

// File: rtl/sync_serial_shifter.sv
module sync_serial_shifter #(
  parameter int HALF_PERIOD = 4,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         master,
  input  logic         lsb_first,
  input  logic         idle_level,
  input  logic         tx_wr,
  input  logic [W-1:0] tx_data,
  output logic         tx_empty,
  input  logic         rx_rd,
  output logic [W-1:0] rx_data,
  output logic         rx_full,
  output logic         overrun,
  output logic         busy,
  input  logic         sclk_in,
  output logic         sclk_out,
  output logic         sclk_oe,
  input  logic         sdata_in,
  output logic         sdata_out
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam int DIVW = $clog2(HALF_PERIOD + 1);

  logic [W-1:0]    tx_reg, tx_sh, rx_sh;
  logic [CW-1:0]   bit_idx;
  logic [DIVW-1:0] div;
  logic            sclk_r;
  logic [2:0]      sync;

  wire s_rise   = sync[1] & ~sync[2];
  wire s_fall   = ~sync[1] & sync[2];
  wire last_idx = (bit_idx == CW'(W-1));
  wire m_tick   = busy && master && (div == DIVW'(HALF_PERIOD-1));
  wire sample   = busy && (master ? (m_tick && !sclk_r) : s_rise);
  wire step     = busy && !last_idx && (master ? (m_tick && sclk_r) : s_fall);
  wire stop     = busy && last_idx && (master ? (m_tick && sclk_r) : s_rise);
  wire deliver  = sample && last_idx;
  wire load     = !busy && (master ? !tx_empty : s_fall);

  wire [W-1:0]  rx_next = lsb_first ? {sdata_in, rx_sh[W-1:1]} : {rx_sh[W-2:0], sdata_in};
  wire [CW-1:0] out_pos = lsb_first ? bit_idx : CW'(W-1) - bit_idx;

  assign sdata_out = busy ? tx_sh[out_pos] : idle_level;
  assign sclk_out  = master ? sclk_r : 1'b1;
  assign sclk_oe   = master;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync     <= '1;
      tx_reg   <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      rx_data  <= '0;
      tx_empty <= 1'b1;
      rx_full  <= 1'b0;
      overrun  <= 1'b0;
      busy     <= 1'b0;
      bit_idx  <= '0;
      div      <= '0;
      sclk_r   <= 1'b1;
    end else begin
      sync <= {sync[1:0], sclk_in};

      if (tx_wr) begin
        tx_reg   <= tx_data;
        tx_empty <= 1'b0;
      end else if (load) begin
        tx_empty <= 1'b1;
      end

      if (load) begin
        tx_sh   <= tx_reg;
        busy    <= 1'b1;
        bit_idx <= '0;
        div     <= '0;
        sclk_r  <= !master;
      end else if (busy) begin
        if (master) begin
          if (m_tick) begin
            div <= '0;
            if (!(sclk_r && last_idx)) sclk_r <= ~sclk_r;
          end else begin
            div <= div + 1'b1;
          end
        end
        if (sample) rx_sh <= rx_next;
        if (step) bit_idx <= bit_idx + 1'b1;
        if (stop) begin
          busy   <= 1'b0;
          sclk_r <= 1'b1;
        end
      end

      if (deliver) begin
        if (rx_full && !rx_rd) begin
          overrun <= 1'b1;
        end else begin
          rx_data <= rx_next;
          rx_full <= 1'b1;
          if (rx_rd) overrun <= 1'b0;
        end
      end else if (rx_rd) begin
        rx_full <= 1'b0;
        overrun <= 1'b0;
      end
    end
  end

  assert_clk_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !busy) |-> sclk_out);

  assert_master_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (master && $past(master) && $rose(busy)) |-> !$past(tx_empty));

  assert_data_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (master && busy && sclk_out && $past(sclk_out) && $past(busy)) |-> $stable(sdata_out));

  assert_load_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (tx_empty || $past(tx_wr)));

  assert_hold_unread_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rx_rd) |=> $stable(rx_data));
endmodule

// File: tb/sync_serial_shifter_tb_top.sv
module sync_serial_shifter_tb_top;
  localparam int H = 4;
  localparam int SH = 8;

  logic clk = 0, rst_n = 0;
  logic master = 1, lsb_first = 0, idle_level = 0, tx_wr = 0, rx_rd = 0;
  logic sclk_in = 1, sdata_in = 0;
  logic [7:0] tx_data = 0;
  logic tx_empty, rx_full, overrun, busy, sclk_out, sclk_oe, sdata_out;
  logic [7:0] rx_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sync_serial_shifter #(.HALF_PERIOD(H), .W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .master(master), .lsb_first(lsb_first),
    .idle_level(idle_level), .tx_wr(tx_wr), .tx_data(tx_data), .tx_empty(tx_empty),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full), .overrun(overrun),
    .busy(busy), .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .sdata_in(sdata_in), .sdata_out(sdata_out));

  function automatic logic ob(input logic [7:0] b, input int k, input logic lsb);
    return lsb ? b[k] : b[7-k];
  endfunction

  function automatic logic [7:0] put(input logic [7:0] acc, input int k, input logic lsb, input logic v);
    logic [7:0] r = acc;
    if (lsb) r[k] = v; else r[7-k] = v;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_tx(input logic [7:0] b);
    @(negedge clk); tx_data = b; tx_wr = 1;
    @(negedge clk); tx_wr = 0;
    chk(tx_empty == 0, "R7 write clears empty", tx_empty, 0);
  endtask

  task automatic read_rx();
    @(negedge clk); rx_rd = 1;
    @(negedge clk); rx_rd = 0;
    chk(rx_full == 0 && overrun == 0, "R8 R9 read clears flags", {rx_full, overrun}, 0);
  endtask

  task automatic master_xfer(input logic [7:0] tb, input logic [7:0] pb, input logic lsb,
                             input logic idl, input bit do_read);
    logic [7:0] cap = 0;
    int rises = 0, low = 0, k = 0;
    bit bad_phase = 0, bad_stable = 0;
    logic prev, last_bit = 0;
    @(negedge clk); master = 1; lsb_first = lsb; idle_level = idl;
    @(negedge clk);
    chk(sdata_out == idl, "R6 idle level before", sdata_out, idl);
    write_tx(tb);
    prev = sclk_out;
    while (busy || rises == 0) begin
      if (prev && !sclk_out) begin
        sdata_in = ob(pb, k, lsb); k++; low = 0;
      end
      if (!sclk_out) low++;
      if (!prev && sclk_out) begin
        if (low != H) bad_phase = 1;
        last_bit = sdata_out;
        cap = put(cap, rises, lsb, sdata_out);
        rises++;
      end else if (prev && sclk_out && busy && rises > 0 && sdata_out != last_bit) begin
        bad_stable = 1;
      end
      prev = sclk_out;
      @(negedge clk);
    end
    chk(rises == 8, "R2 pulse count", rises, 8);
    chk(!bad_phase, "R2 low phase length", bad_phase, 0);
    chk(!bad_stable, "R4 data stable while high", bad_stable, 0);
    chk(cap == tb, "R5 transmitted byte order", cap, tb);
    chk(sclk_out == 1, "R2 clock idles high", sclk_out, 1);
    chk(sdata_out == idl, "R6 idle level after", sdata_out, idl);
    chk(tx_empty == 1, "R7 empty after load", tx_empty, 1);
    if (do_read) begin
      chk(rx_full == 1 && rx_data == pb, "R8 R5 received byte", rx_data, pb);
      read_rx();
    end
  endtask

  task automatic slave_xfer(input logic [7:0] tb, input logic [7:0] pb, input logic lsb,
                            input logic idl);
    logic [7:0] cap = 0;
    @(negedge clk); master = 0; lsb_first = lsb; idle_level = idl;
    write_tx(tb);
    repeat (3) @(negedge clk);
    chk(sclk_oe == 0 && sclk_out == 1, "R10 slave clock not driven", {sclk_oe, sclk_out}, 1);
    chk(sdata_out == idl, "R6 slave idle level", sdata_out, idl);
    for (int k = 0; k < 8; k++) begin
      sclk_in = 0; sdata_in = ob(pb, k, lsb);
      repeat (SH) @(negedge clk);
      cap = put(cap, k, lsb, sdata_out);
      sclk_in = 1;
      repeat (SH) @(negedge clk);
    end
    chk(busy == 0, "R10 slave done", busy, 0);
    chk(cap == tb, "R11 R5 slave transmitted byte", cap, tb);
    chk(tx_empty == 1, "R11 slave load sets empty", tx_empty, 1);
    chk(rx_full == 1 && rx_data == pb, "R10 slave received byte", rx_data, pb);
    read_rx();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    chk(tx_empty == 1 && rx_full == 0 && overrun == 0 && busy == 0, "R1 reset flags",
        {tx_empty, rx_full, overrun, busy}, 4'b1000);
    chk(sclk_out == 1 && sdata_out == 0, "R1 reset lines", {sclk_out, sdata_out}, 2'b10);
    rst_n = 1;
    repeat (40) @(negedge clk);
    chk(busy == 0 && sclk_out == 1, "R3 no start when empty", {busy, sclk_out}, 1);

    master_xfer(8'hA5, 8'h3C, 0, 1, 1);
    master_xfer(8'h01, 8'h80, 1, 0, 1);
    master_xfer(8'h80, 8'h01, 0, 0, 1);

    master_xfer(8'h11, 8'h5A, 0, 0, 0);
    master_xfer(8'h22, 8'hC3, 1, 1, 0);
    chk(overrun == 1, "R9 overrun set", overrun, 1);
    chk(rx_data == 8'h5A, "R9 earlier byte kept", rx_data, 8'h5A);
    read_rx();

    for (int i = 0; i < 12; i++)
      master_xfer(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 1);
    slave_xfer(8'hC1, 8'h7E, 0, 1);
    slave_xfer(8'h0F, 8'hE2, 1, 0);
    for (int i = 0; i < 6; i++)
      slave_xfer(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule